// File: doc/BRIEF.md
# Serial Control Register Port

This block is the target side of a three-wire control link: an active-high enable, a serial clock and a serial data input. A host sends 31-bit frames while enable is high. The first bit sets the direction. Six address bits follow, then 24 data bits, each field most significant bit first. The host changes the data line on falling serial-clock edges and the block samples it on rising edges.

A write frame commits its data to one word of a 64-entry, 24-bit register file. A read frame returns the addressed word on a shared output pin. When the pin is not carrying read data, it repeats a lock-detect input. Two bits of register 0x1A select which source the pin shows.

The serial signals are brought into the system clock domain through a synchronizer. The block finds the serial-clock edges by oversampling, so the serial clock must run several times slower than the system clock.

Top module: `serctl_slave`

## Requirements
- R1: After reset every register reads zero, and the pin follows the lock-detect input.
- R2: A frame whose first sampled bit is 0 is a write. After the flag, six address bits and then 24 data bits arrive, both MSB first, sampled on rising edges 2–7 and 8–31. The 24-bit word is stored in the addressed register.
- R3: A frame whose first bit is 1 is a read. The addressed word is driven MSB first, one bit after each falling edge that follows rising edges 7 through 30, so each bit is valid at rising edges 8 through 31. A read changes no register.
- R4: If enable drops before the 31st rising edge, no register changes.
- R5: The bit count restarts each time enable goes low, so a full frame that follows an aborted one is decoded correctly.
- R6: When bits 12 and 13 of register 0x1A are both 0, the pin always shows lock detect, including during read frames.
- R7: When bit 12 of register 0x1A is 1 and bit 13 is 0, the pin shows the data-out signal only while enable is high in a frame whose flag was sampled as 1. In every other case it shows lock detect, including during write frames.
- R8: When bit 13 of register 0x1A is 1, the pin shows the data-out signal at all times, whatever the state of bit 12.
- R9: The data-out signal is 0 whenever no read bit is being driven: while enable is low, during write frames, and during the flag and address phase of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also used to oversample the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sen_i | input | 1 | Frame enable from the host, active high |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| lock_i | input | 1 | Lock-detect status, treated as a plain digital level |
| pin_o | output | 1 | Shared output: lock detect or serial read data |

## Verification
Every address is written with a different value computed from its index. All 64 words are read back both before the writes and after them. This separates address decoding, bit order and reset contents, since a swapped or shifted field would return a neighbour's value. Frames are aborted after 20 and after 30 bits, the second stopping one bit short of commit, and each is followed by a read and then a complete frame. This shows whether commits happen early or whether the counter fails to restart. The pin is sampled in the address phase of read and write frames and between frames, with lock detect held opposite to the expected data-out level, under each of the three mux settings. This distinguishes which source the mux has chosen.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 24;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int DATA_FIRST = 1 + ADDR_W;

    localparam logic [ADDR_W-1:0] MUX_ADDR = 6'h1A;
    localparam int AUTO_BIT  = 12;
    localparam int FORCE_BIT = 13;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic              load;
        logic              shift;
        logic [ADDR_W-1:0] addr;
    } rd_req_t;

    typedef enum logic {
        SRC_LOCK = 1'b0,
        SRC_DATA = 1'b1
    } pin_src_e;

    function automatic pin_src_e pin_sel(input logic force_on,
                                         input logic auto_on,
                                         input logic rd_frame);
        if (force_on)             return SRC_DATA;
        if (auto_on && rd_frame)  return SRC_DATA;
        return SRC_LOCK;
    endfunction

endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic sen_i,
    input  logic sdi_i,
    output logic sck_s,
    output logic sen_s,
    output logic sdi_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sck_p, sen_p, sdi_p;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            sen_p <= '0;
            sdi_p <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_p <= (sck_p << 1) | STAGES'(sck_i);
            sen_p <= (sen_p << 1) | STAGES'(sen_i);
            sdi_p <= (sdi_p << 1) | STAGES'(sdi_i);
            sck_d <= sck_p[STAGES-1];
        end
    end

    assign sck_s = sck_p[STAGES-1];
    assign sen_s = sen_p[STAGES-1];
    assign sdi_s = sdi_p[STAGES-1];
    assign rise  = sck_s & ~sck_d;
    assign fall  = ~sck_s & sck_d;

endmodule

// File: rtl/serctl_frame.sv
module serctl_frame
    import serctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sen_s,
    input  logic    sdi_s,
    input  logic    rise,
    input  logic    fall,
    output wr_req_t wr,
    output rd_req_t rd,
    output logic    rd_frame
);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] D_FIRST  = CNT_W'(DATA_FIRST);

    logic [CNT_W-1:0]  cnt;
    logic              flag;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-2:0] data_sh;
    logic              sample;

    assign sample = sen_s & rise & (cnt != FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            flag    <= 1'b0;
            addr_sh <= '0;
            data_sh <= '0;
        end else if (!sen_s) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (sample) begin
            cnt <= cnt + 1'b1;
            if (cnt == '0)
                flag <= sdi_s;
            else if (cnt <= ADDR_END)
                addr_sh <= {addr_sh[ADDR_W-2:0], sdi_s};
            else
                data_sh <= {data_sh[DATA_W-3:0], sdi_s};
        end
    end

    always_comb begin
        wr.en    = sample & (cnt == LAST) & ~flag;
        wr.addr  = addr_sh;
        wr.data  = {data_sh, sdi_s};
        rd.load  = sample & (cnt == ADDR_END) & flag;
        rd.addr  = {addr_sh[ADDR_W-2:0], sdi_s};
        rd.shift = sen_s & fall & flag & (cnt >= D_FIRST) & (cnt <= LAST);
        rd_frame = sen_s & flag;
    end

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !sen_s |=> (cnt == '0));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sen_s && rise && cnt == FULL) |=> (cnt == FULL));

    // R4
    commit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> ($past(sen_s) && sen_s));

endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank
    import serctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sen_s,
    input  wr_req_t wr,
    input  rd_req_t rd,
    output logic    sdo,
    output logic    ctrl_auto,
    output logic    ctrl_force
);
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr.en) begin
            regs[wr.addr] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (!sen_s) begin
            sdo <= 1'b0;
        end else if (rd.load) begin
            sh <= regs[rd.addr];
        end else if (rd.shift) begin
            sdo <= sh[DATA_W-1];
            sh  <= {sh[DATA_W-2:0], 1'b0};
        end
    end

    assign ctrl_auto  = regs[MUX_ADDR][AUTO_BIT];
    assign ctrl_force = regs[MUX_ADDR][FORCE_BIT];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (regs[$past(wr.addr)] == $past(wr.data)));

    // R3
    read_load_chk: assert property (@(posedge clk) disable iff (rst)
        rd.load |=> (sh == $past(regs[rd.addr])));

    // R4
    ctrl_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> ($stable(ctrl_auto) && $stable(ctrl_force)));

endmodule

// File: rtl/serctl_slave.sv
module serctl_slave
    import serctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sen_i,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic lock_i,
    output logic pin_o
);
    logic    sck_s, sen_s, sdi_s, rise, fall;
    logic    rd_frame, sdo, ctrl_auto, ctrl_force;
    wr_req_t wr;
    rd_req_t rd;

    serctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck_i(sck_i), .sen_i(sen_i), .sdi_i(sdi_i),
        .sck_s(sck_s), .sen_s(sen_s), .sdi_s(sdi_s),
        .rise(rise), .fall(fall)
    );

    serctl_frame u_frame (
        .clk(clk), .rst(rst),
        .sen_s(sen_s), .sdi_s(sdi_s), .rise(rise), .fall(fall),
        .wr(wr), .rd(rd), .rd_frame(rd_frame)
    );

    serctl_regbank u_bank (
        .clk(clk), .rst(rst), .sen_s(sen_s),
        .wr(wr), .rd(rd),
        .sdo(sdo), .ctrl_auto(ctrl_auto), .ctrl_force(ctrl_force)
    );

    assign pin_o = (pin_sel(ctrl_force, ctrl_auto, rd_frame) == SRC_DATA) ? sdo : lock_i;

    // R8
    force_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_force && !sen_s && $past(!sen_s) && !sck_s) |-> !pin_o);

endmodule

// File: tb/sim_serctl_slave.sv
module sim_serctl_slave;

    localparam int H   = 4;
    localparam int GAP = 70;

    logic clk = 1'b0;
    logic rst, sen, sck, sdi, lock, pin;
    int   tests = 0;
    int   fails = 0;
    logic [23:0] rdword;
    logic        probe3;

    always #5 clk = ~clk;

    serctl_slave u0 (
        .clk(clk), .rst(rst), .sen_i(sen), .sck_i(sck), .sdi_i(sdi),
        .lock_i(lock), .pin_o(pin)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int a);
        logic [23:0] v;
        v = 24'(a * 32'h01F3D5) ^ {4{6'(a)}};
        if (a == 26) v = (v & ~24'h003000) | 24'h001000;
        return v;
    endfunction

    task automatic frame(input logic flag, input logic [5:0] a,
                         input logic [23:0] d, input int nbits);
        logic [30:0] f;
        f = {flag, a, d};
        rdword = '0;
        sen = 1'b1;
        sdi = f[30];
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i >= 7) rdword = {rdword[22:0], pin};
            if (i == 3) probe3 = pin;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
            if (i < 30) sdi = f[29-i];
            repeat (H) @(negedge clk);
        end
        sen = 1'b0;
        sdi = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; sen = 1'b0; sck = 1'b0; sdi = 1'b0; lock = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: pin follows lock after reset
        chk("R1 pin lock=0", 24'(pin), 24'h0);
        lock = 1'b1; #1;
        chk("R1 pin lock=1", 24'(pin), 24'h1);

        // R6: mux bits clear, read frame still shows lock
        frame(1'b1, 6'd3, 24'h0, 31);
        chk("R6 read shows lock", rdword, 24'hFFFFFF);
        chk("R6 addr phase lock", 24'(probe3), 24'h1);

        // R7: enable auto switching
        frame(1'b0, 6'h1A, 24'h001000, 31);
        chk("R7 idle shows lock", 24'(pin), 24'h1);

        // R1 R3: reset contents read back
        for (int a = 0; a < 64; a++) begin
            frame(1'b1, 6'(a), 24'h0, 31);
            chk("R1 reset value", rdword, (a == 26) ? 24'h001000 : 24'h0);
            chk("R9 read addr phase zero", 24'(probe3), 24'h0);
        end

        // R2 R7: write every address, pin shows lock during writes
        for (int a = 0; a < 64; a++) begin
            frame(1'b0, 6'(a), pat(a), 31);
            chk("R7 write frame lock", 24'(probe3), 24'h1);
        end

        lock = 1'b0;
        for (int a = 0; a < 64; a++) begin
            frame(1'b1, 6'(a), 24'h0, 31);
            chk("R2 R3 readback", rdword, pat(a));
        end
        frame(1'b1, 6'd9, 24'h0, 31);
        chk("R3 read leaves value", rdword, pat(9));

        // R4: aborted writes
        frame(1'b0, 6'd5, ~pat(5), 20);
        frame(1'b1, 6'd5, 24'h0, 31);
        chk("R4 abort at 20", rdword, pat(5));
        frame(1'b0, 6'd5, ~pat(5), 30);
        frame(1'b1, 6'd5, 24'h0, 31);
        chk("R4 abort at 30", rdword, pat(5));

        // R5: full frame after abort
        frame(1'b0, 6'd5, 24'hABCDEF, 31);
        frame(1'b1, 6'd5, 24'h0, 31);
        chk("R5 frame after abort", rdword, 24'hABCDEF);

        // R8: force data-out
        frame(1'b0, 6'h1A, 24'h002000, 31);
        lock = 1'b1; #1;
        chk("R8 R9 idle forced zero", 24'(pin), 24'h0);
        frame(1'b1, 6'd5, 24'h0, 31);
        chk("R8 forced read", rdword, 24'hABCDEF);
        frame(1'b0, 6'd7, 24'h123456, 31);
        chk("R8 R9 write frame zero", 24'(probe3), 24'h0);

        // R6: back to lock detect
        frame(1'b0, 6'h1A, 24'h0, 31);
        chk("R6 restored lock=1", 24'(pin), 24'h1);
        lock = 1'b0; #1;
        chk("R6 restored lock=0", 24'(pin), 24'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule